// File: doc/BRIEF.md
# Transmit Link Reset Sequencer

This block is the user-side controller that walks a JESD204B-style transmit link through reset and back to an operational state. It drives three reset outputs: an active-low configuration-bus reset, an active-low core link reset and an active-high transceiver reconfiguration reset. It does this in a fixed order. First it waits for the core PLL to lock. Next it runs a configuration phase. It releases the link reset only once the link core has acknowledged that its channels are held in reset, and then it waits for out-of-reset and for the two ready flags.

In subclass 1 operation the sequencer asks the clock generator for a one-shot SYSREF pulse when the link fails to come up on its own. It retries a bounded number of times and then reports a link failure. A full reset or a link-only reset can be requested at any time. A request is acted on only while the core's reset acknowledge is high, and until then it is held pending.

Top module: `tx_link_rst_seq`

## Requirements
- R1: Out of `rst_ni` and on every full reset, `cfg_rst_no`=0, `link_rst_no`=0 and `reconfig_rst_o`=1 are applied in the same cycle, and `state_o` reads 0.
- R2: Whenever `cfg_rst_no` is 0 or `reconfig_rst_o` is 1, `link_rst_no` is 0. A link-only reset never drives `cfg_rst_no` low.
- R3: In the full-reset state the sequencer stays put until `pll_locked_i` is high. In the next cycle it releases `cfg_rst_no` and `reconfig_rst_o` and raises `cfg_busy_o`, while `link_rst_no` stays 0.
- R4: After the configuration phase, `link_rst_no` rises only in the cycle after `rst_ack_ni` was sampled low.
- R5: A one-cycle `cfg_done_i` ends the configuration phase. If `CFG_TMO_CYC` cycles pass in that phase without it, `cfg_timeout_o` rises exactly `CFG_TMO_CYC` cycles after `cfg_busy_o` rose, and `link_rst_no` is held low. In that error state, either request type starts a full reset at once.
- R6: `out_of_reset_i` passes a two-flop synchronizer. In subclass 1, with no ready flags, the first `sysref_req_o` pulse is seen `SYSREF_WAIT_CYC`+3 cycles after `out_of_reset_i` rises.
- R7: With `subclass1_i`=1, while both ready flags are not high after out-of-reset, `sysref_req_o` pulses for one cycle every `SYSREF_WAIT_CYC` cycles. It pulses at most `SYSREF_RETRIES` times, and `SYSREF_WAIT_CYC` cycles after the last pulse `link_fail_o` rises. With `subclass1_i`=0 there are no pulses and no failure.
- R8: `operational_o` rises only after `link_ready_i` and `frame_ready_i` are both sampled high.
- R9: A request is taken only in the running, failed, out-of-reset-wait or ready-wait states, and only while `rst_ack_ni` is high. A request made otherwise is held pending and is acted on once this condition holds. A pending full request wins over a pending link-only request.
- R10: A link-only request from the running state drives `link_rst_no` low and keeps the other two resets released. It then repeats the acknowledge, release and ready steps.
- R11: `state_o` codes are: 0 full reset, 1 configuring, 2 configuration timeout, 3 acknowledge wait, 4 link release, 5 out-of-reset wait, 6 ready wait, 7 running, 8 link failed. `cfg_busy_o`, `operational_o`, `cfg_timeout_o` and `link_fail_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| full_req_i | input | 1 | Request for a full reset |
| link_req_i | input | 1 | Request for a link-only reset |
| subclass1_i | input | 1 | Subclass 1 operation, SYSREF requests enabled |
| pll_locked_i | input | 1 | Core PLL lock |
| cfg_done_i | input | 1 | Configuration phase finished (pulse) |
| rst_ack_ni | input | 1 | Core reset acknowledge, low while channels held in reset |
| out_of_reset_i | input | 1 | Core out-of-reset status, asynchronous |
| link_ready_i | input | 1 | Link ready status |
| frame_ready_i | input | 1 | Frame ready status |
| cfg_rst_no | output | 1 | Configuration-bus reset, active low |
| link_rst_no | output | 1 | Core link reset, active low |
| reconfig_rst_o | output | 1 | Transceiver reconfiguration reset, active high |
| cfg_busy_o | output | 1 | Configuration phase in progress |
| sysref_req_o | output | 1 | One-cycle SYSREF pulse request |
| operational_o | output | 1 | Link running |
| cfg_timeout_o | output | 1 | Configuration phase timed out |
| link_fail_o | output | 1 | Link failed after all SYSREF retries |
| state_o | output | 4 | Sequencer state code |

## Verification
The hardest situation to reach from the ports is a request that arrives while the core holds its acknowledge low, in a state that would otherwise accept it. A real core only keeps the acknowledge low while the link reset is asserted, so that case never arises by itself. The bench's core model therefore has an override that pins the acknowledge low while the link is running. Under that override the bench issues a link-only request and then a full request, and checks that neither reset moves. It then lifts the override and expects the full sequence to run. The retry exhaustion path is reached by a core model that never raises the ready flags, with short wait windows set as parameters.

// File: rtl/tx_rst_pkg.sv
`timescale 1ns/1ps
package tx_rst_pkg;
  typedef enum logic [3:0] {
    ST_FULL_RST  = 4'd0,
    ST_CFG       = 4'd1,
    ST_CFG_ERR   = 4'd2,
    ST_ACK_WAIT  = 4'd3,
    ST_LINK_REL  = 4'd4,
    ST_OOR_WAIT  = 4'd5,
    ST_RDY_WAIT  = 4'd6,
    ST_RUN       = 4'd7,
    ST_FAIL      = 4'd8
  } seq_state_e;
endpackage

// File: rtl/tx_rst_sync.sv
`timescale 1ns/1ps
module tx_rst_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tx_rst_timer.sv
`timescale 1ns/1ps
module tx_rst_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] lim_m1_i,
  output logic         exp_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign exp_o = (cnt_q == lim_m1_i);
endmodule

// File: rtl/tx_rst_req.sv
`timescale 1ns/1ps
module tx_rst_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic full_req_i,
  input  logic link_req_i,
  input  logic accept_i,
  input  logic force_full_i,
  output logic take_full_o,
  output logic take_link_o
);
  logic full_pend_q, link_pend_q;
  logic full_any, link_any;

  assign full_any    = full_req_i | full_pend_q;
  assign link_any    = link_req_i | link_pend_q;
  // error state turns any request into a full restart
  assign take_full_o = accept_i & (full_any | (force_full_i & link_any));
  assign take_link_o = accept_i & link_any & ~full_any & ~force_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_pend_q <= 1'b0;
      link_pend_q <= 1'b0;
    end else begin
      full_pend_q <= take_full_o ? 1'b0 : full_any;
      link_pend_q <= (take_full_o | take_link_o) ? 1'b0 : link_any;
    end
  end
endmodule

// File: rtl/tx_link_rst_seq.sv
`timescale 1ns/1ps
module tx_link_rst_seq
  import tx_rst_pkg::*;
#(
  parameter int CFG_TMO_CYC     = 100000,
  parameter int SYSREF_WAIT_CYC = 4096,
  parameter int SYSREF_RETRIES  = 3,
  parameter int SYNC_STAGES     = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       full_req_i,
  input  logic       link_req_i,
  input  logic       subclass1_i,
  input  logic       pll_locked_i,
  input  logic       cfg_done_i,
  input  logic       rst_ack_ni,
  input  logic       out_of_reset_i,
  input  logic       link_ready_i,
  input  logic       frame_ready_i,
  output logic       cfg_rst_no,
  output logic       link_rst_no,
  output logic       reconfig_rst_o,
  output logic       cfg_busy_o,
  output logic       sysref_req_o,
  output logic       operational_o,
  output logic       cfg_timeout_o,
  output logic       link_fail_o,
  output logic [3:0] state_o
);
  localparam int TMR_MAX = (CFG_TMO_CYC > SYSREF_WAIT_CYC) ? CFG_TMO_CYC : SYSREF_WAIT_CYC;
  localparam int CNT_W   = $clog2(TMR_MAX + 1);
  localparam int RTY_W   = $clog2(SYSREF_RETRIES + 2);
  localparam logic [CNT_W-1:0] CFG_LIM_M1 = CNT_W'(CFG_TMO_CYC - 1);
  localparam logic [CNT_W-1:0] SYS_LIM_M1 = CNT_W'(SYSREF_WAIT_CYC - 1);
  localparam logic [RTY_W-1:0] RTY_MAX    = RTY_W'(SYSREF_RETRIES);

  seq_state_e       state_q, state_d;
  logic             oor_s;
  logic             tmr_clr, tmr_exp;
  logic [CNT_W-1:0] tmr_lim;
  logic [RTY_W-1:0] rty_q;
  logic             rdy_all, in_rdy_wait, no_link;
  logic             sysref_fire, retry_out, sysref_q;
  logic             accept_ok, in_err, take_full, take_link;

  tx_rst_sync #(.STAGES(SYNC_STAGES), .W(1)) u_oor_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (out_of_reset_i),
    .q_o   (oor_s)
  );

  assign in_err    = (state_q == ST_CFG_ERR);
  assign accept_ok = in_err |
                     (rst_ack_ni & ((state_q == ST_RUN) | (state_q == ST_FAIL) |
                                    (state_q == ST_OOR_WAIT) | (state_q == ST_RDY_WAIT)));

  tx_rst_req u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .full_req_i  (full_req_i),
    .link_req_i  (link_req_i),
    .accept_i    (accept_ok),
    .force_full_i(in_err),
    .take_full_o (take_full),
    .take_link_o (take_link)
  );

  assign rdy_all     = link_ready_i & frame_ready_i;
  assign in_rdy_wait = (state_q == ST_RDY_WAIT);
  assign no_link     = in_rdy_wait & subclass1_i & ~rdy_all & tmr_exp;
  assign sysref_fire = no_link & (rty_q < RTY_MAX);
  assign retry_out   = no_link & (rty_q >= RTY_MAX);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FULL_RST: if (pll_locked_i) state_d = ST_CFG;
      ST_CFG: begin
        if (cfg_done_i)   state_d = ST_ACK_WAIT;
        else if (tmr_exp) state_d = ST_CFG_ERR;
      end
      ST_CFG_ERR:  state_d = ST_CFG_ERR;
      ST_ACK_WAIT: if (!rst_ack_ni) state_d = ST_LINK_REL;
      ST_LINK_REL: if (rst_ack_ni) state_d = ST_OOR_WAIT;
      ST_OOR_WAIT: if (oor_s) state_d = ST_RDY_WAIT;
      ST_RDY_WAIT: begin
        if (rdy_all)        state_d = ST_RUN;
        else if (retry_out) state_d = ST_FAIL;
      end
      ST_RUN, ST_FAIL: state_d = state_q;
      default: state_d = ST_FULL_RST;
    endcase
    if (take_full)      state_d = ST_FULL_RST;
    else if (take_link) state_d = ST_ACK_WAIT;
  end

  assign tmr_lim = (state_q == ST_CFG) ? CFG_LIM_M1 : SYS_LIM_M1;
  assign tmr_clr = (state_d != state_q) | sysref_fire;

  tx_rst_timer #(.W(CNT_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tmr_clr),
    .lim_m1_i(tmr_lim),
    .exp_o   (tmr_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_FULL_RST;
      rty_q    <= '0;
      sysref_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      sysref_q <= sysref_fire;
      if (!in_rdy_wait)     rty_q <= '0;
      else if (sysref_fire) rty_q <= rty_q + 1'b1;
    end
  end

  assign cfg_rst_no     = (state_q != ST_FULL_RST);
  assign reconfig_rst_o = (state_q == ST_FULL_RST);
  assign link_rst_no    = (state_q == ST_LINK_REL) | (state_q == ST_OOR_WAIT) |
                          (state_q == ST_RDY_WAIT) | (state_q == ST_RUN) | (state_q == ST_FAIL);
  assign cfg_busy_o     = (state_q == ST_CFG);
  assign sysref_req_o   = sysref_q;
  assign operational_o  = (state_q == ST_RUN);
  assign cfg_timeout_o  = in_err;
  assign link_fail_o    = (state_q == ST_FAIL);
  assign state_o        = state_q;
endmodule

// File: rtl/tx_link_rst_seq_chk.sv
`timescale 1ns/1ps
module tx_link_rst_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pll_locked_i,
  input logic       rst_ack_ni,
  input logic       link_ready_i,
  input logic       frame_ready_i,
  input logic       cfg_rst_no,
  input logic       link_rst_no,
  input logic       reconfig_rst_o,
  input logic       cfg_busy_o,
  input logic       sysref_req_o,
  input logic       operational_o,
  input logic       cfg_timeout_o,
  input logic       link_fail_o
);
  p_full_together_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_rst_no) |-> (reconfig_rst_o && !link_rst_no));

  p_link_with_cfg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_rst_no || reconfig_rst_o) |-> !link_rst_no);

  p_cfg_after_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_rst_no) |-> $past(pll_locked_i));

  p_release_after_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_rst_no) |-> !$past(rst_ack_ni));

  p_timeout_holds_link_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_timeout_o |-> !link_rst_no);

  p_sysref_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysref_req_o |=> !sysref_req_o);

  p_run_after_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(operational_o) |-> $past(link_ready_i && frame_ready_i));

  p_reset_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_rst_no) |-> $past(rst_ack_ni));

  p_status_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cfg_busy_o, operational_o, cfg_timeout_o, link_fail_o}));
endmodule

bind tx_link_rst_seq tx_link_rst_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pll_locked_i  (pll_locked_i),
  .rst_ack_ni    (rst_ack_ni),
  .link_ready_i  (link_ready_i),
  .frame_ready_i (frame_ready_i),
  .cfg_rst_no    (cfg_rst_no),
  .link_rst_no   (link_rst_no),
  .reconfig_rst_o(reconfig_rst_o),
  .cfg_busy_o    (cfg_busy_o),
  .sysref_req_o  (sysref_req_o),
  .operational_o (operational_o),
  .cfg_timeout_o (cfg_timeout_o),
  .link_fail_o   (link_fail_o)
);

// File: tb/tx_link_rst_seq_bench.sv
`timescale 1ns/1ps
module tx_link_rst_seq_bench;
  localparam int CFG_TMO = 20;
  localparam int SWAIT   = 8;
  localparam int RETRIES = 2;

  localparam int M_NONE = 0, M_FREE = 1, M_AFTER = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic full_req_i = 0, link_req_i = 0, subclass1_i = 1, pll_locked_i = 0, cfg_done_i = 0;
  logic rst_ack_ni = 1, out_of_reset_i = 0, link_ready_i = 0, frame_ready_i = 0;
  logic cfg_rst_no, link_rst_no, reconfig_rst_o, cfg_busy_o, sysref_req_o;
  logic operational_o, cfg_timeout_o, link_fail_o;
  logic [3:0] state_o;

  always #2.5 clk = ~clk;

  tx_link_rst_seq #(
    .CFG_TMO_CYC(CFG_TMO), .SYSREF_WAIT_CYC(SWAIT), .SYSREF_RETRIES(RETRIES), .SYNC_STAGES(2)
  ) u_tx_link_rst_seq (
    .clk_i(clk), .rst_ni(rst_ni), .full_req_i(full_req_i), .link_req_i(link_req_i),
    .subclass1_i(subclass1_i), .pll_locked_i(pll_locked_i), .cfg_done_i(cfg_done_i),
    .rst_ack_ni(rst_ack_ni), .out_of_reset_i(out_of_reset_i), .link_ready_i(link_ready_i),
    .frame_ready_i(frame_ready_i), .cfg_rst_no(cfg_rst_no), .link_rst_no(link_rst_no),
    .reconfig_rst_o(reconfig_rst_o), .cfg_busy_o(cfg_busy_o), .sysref_req_o(sysref_req_o),
    .operational_o(operational_o), .cfg_timeout_o(cfg_timeout_o), .link_fail_o(link_fail_o),
    .state_o(state_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] out_vec();
    return {cfg_rst_no, link_rst_no, reconfig_rst_o, cfg_busy_o,
            sysref_req_o, operational_o, cfg_timeout_o, link_fail_o};
  endfunction

  // core model state
  int  mode = M_FREE;
  bit  ack_force = 0;
  bit  ack_m = 1, oor_m = 0, sys_rdy = 0;
  int  ack_cnt = 0, oor_cnt = 0, rdy_cnt = 0, sys_cnt = 0;
  // monitor state
  int  cyc = 0, oor_cyc = 0, last_pulse = 0, cfg_cyc = 0, n_pulse = 0, cfg_low = 0;
  bit  oor_valid = 0, have_last = 0, time_chk = 0;
  bit  mon_en = 0, primed = 0;
  logic [7:0] prev, cur, e;

  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      if (!link_rst_no) begin
        oor_m = 0; rdy_cnt = 0; sys_cnt = 0; sys_rdy = 0; oor_cnt = 0;
        if (ack_m) begin
          ack_cnt++;
          if (ack_cnt >= 3) begin ack_m = 0; ack_cnt = 0; end
        end
      end else if (!ack_m) begin
        ack_cnt++;
        if (ack_cnt >= 3) begin ack_m = 1; ack_cnt = 0; end
      end else if (!oor_m) begin
        oor_cnt++;
        if (oor_cnt >= 2) begin oor_m = 1; oor_cyc = cyc; oor_valid = 1; end
      end else begin
        if (rdy_cnt < 15) rdy_cnt++;
        if (sysref_req_o && sys_cnt == 0) sys_cnt = 1;
        else if (sys_cnt > 0 && sys_cnt < 3) sys_cnt++;
        if (sys_cnt >= 3) sys_rdy = 1;
      end
    end
    rst_ack_ni     = ack_m & ~ack_force;
    out_of_reset_i = oor_m;
    link_ready_i   = link_rst_no & ((mode == M_FREE && rdy_cnt >= 4) || (mode == M_AFTER && sys_rdy));
    frame_ready_i  = link_ready_i;

    cur = out_vec();
    if (!cfg_rst_no) cfg_low++;
    if (mon_en) begin
      if (!primed) begin
        prev = cur; primed = 1;
      end else if (cur != prev) begin
        if (exp_q.size() == 0) chk(0, "unexpected output change", int'(cur), int'(prev));
        else begin
          e = exp_q.pop_front();
          chk(cur == e, "sequence", int'(cur), int'(e));
        end
        if (cur[3] && !prev[3]) begin
          n_pulse++;
          if (time_chk && have_last) chk(cyc - last_pulse == SWAIT, "R7 pulse spacing", cyc - last_pulse, SWAIT);
          if (time_chk && oor_valid) begin
            chk(cyc - oor_cyc == SWAIT + 3, "R6 sync latency", cyc - oor_cyc, SWAIT + 3);
            oor_valid = 0;
          end
          last_pulse = cyc; have_last = 1;
        end
        if (cur == 8'h90) cfg_cyc = cyc;
        if (cur == 8'h82) chk(cyc - cfg_cyc == CFG_TMO, "R5 timeout length", cyc - cfg_cyc, CFG_TMO);
        prev = cur;
      end
    end
  end

  task automatic pulse_full();
    @(negedge clk) full_req_i = 1; @(negedge clk) full_req_i = 0;
  endtask
  task automatic pulse_link();
    @(negedge clk) link_req_i = 1; @(negedge clk) link_req_i = 0;
  endtask
  task automatic do_cfg_done();
    while (!cfg_busy_o) @(negedge clk);
    cfg_done_i = 1; @(negedge clk) cfg_done_i = 0;
  endtask
  task automatic drain(input string req);
    int k = 0;
    while (exp_q.size() != 0 && k < 500) begin @(negedge clk); k++; end
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(out_vec() == 8'h20, "R1 reset outputs", int'(out_vec()), 8'h20);
    chk(state_o == 4'd0, "R11 reset state code", state_o, 0);
    mon_en = 1;

    // R3: no progress without lock
    repeat (10) @(negedge clk);
    chk(!cfg_rst_no && reconfig_rst_o && !link_rst_no, "R3 hold until lock",
        int'(out_vec()), 8'h20);
    exp_q.push_back(8'h90);
    pll_locked_i = 1;
    exp_q.push_back(8'h80); exp_q.push_back(8'hC0); exp_q.push_back(8'hC4);
    do_cfg_done();
    drain("R3 R4 R8 bring-up");
    chk(operational_o, "R8 operational", operational_o, 1);
    chk(state_o == 4'd7, "R11 running code", state_o, 7);

    // R10: link-only reset keeps config released
    cfg_low = 0;
    exp_q.push_back(8'h80); exp_q.push_back(8'hC0); exp_q.push_back(8'hC4);
    pulse_link();
    drain("R10 link-only sequence");
    chk(cfg_low == 0, "R2 R10 cfg untouched", cfg_low, 0);

    // R9: requests held while acknowledge low, full wins
    ack_force = 1;
    repeat (2) @(negedge clk);
    pulse_link();
    pulse_full();
    repeat (10) @(negedge clk);
    chk(link_rst_no && cfg_rst_no, "R9 request held", int'(out_vec()), 8'hC4);
    exp_q.push_back(8'h20); exp_q.push_back(8'h90);
    ack_force = 0;
    exp_q.push_back(8'h80); exp_q.push_back(8'hC0); exp_q.push_back(8'hC4);
    do_cfg_done();
    drain("R9 pending full taken");

    // R6 R7: retries exhausted
    mode = M_NONE; time_chk = 1; have_last = 0; n_pulse = 0;
    exp_q.push_back(8'h80); exp_q.push_back(8'hC0);
    exp_q.push_back(8'hC8); exp_q.push_back(8'hC0);
    exp_q.push_back(8'hC8); exp_q.push_back(8'hC0);
    exp_q.push_back(8'hC1);
    pulse_link();
    drain("R7 retry sequence");
    time_chk = 0;
    chk(link_fail_o, "R7 link fail", link_fail_o, 1);
    chk(n_pulse == RETRIES, "R7 pulse count", n_pulse, RETRIES);
    chk(state_o == 4'd8, "R11 fail code", state_o, 8);

    // R7: recovery after one SYSREF
    mode = M_AFTER;
    exp_q.push_back(8'h20); exp_q.push_back(8'h90);
    pulse_full();
    exp_q.push_back(8'h80); exp_q.push_back(8'hC0);
    exp_q.push_back(8'hC8); exp_q.push_back(8'hC0); exp_q.push_back(8'hC4);
    do_cfg_done();
    drain("R7 recovery with SYSREF");
    chk(operational_o, "R7 R8 running after SYSREF", operational_o, 1);

    // R5: configuration timeout then restart
    mode = M_FREE;
    exp_q.push_back(8'h20); exp_q.push_back(8'h90); exp_q.push_back(8'h82);
    pulse_full();
    drain("R5 timeout sequence");
    chk(cfg_timeout_o && !link_rst_no, "R5 timeout holds link", int'(out_vec()), 8'h82);
    chk(state_o == 4'd2, "R11 timeout code", state_o, 2);
    exp_q.push_back(8'h20); exp_q.push_back(8'h90);
    pulse_link();
    exp_q.push_back(8'h80); exp_q.push_back(8'hC0); exp_q.push_back(8'hC4);
    do_cfg_done();
    drain("R5 restart from error");

    // R7: subclass 0, no pulses and no failure
    subclass1_i = 0; mode = M_NONE; n_pulse = 0;
    exp_q.push_back(8'h80); exp_q.push_back(8'hC0);
    pulse_link();
    drain("R7 subclass0 entry");
    repeat (40) @(negedge clk);
    chk(!link_fail_o && n_pulse == 0, "R7 subclass0 quiet", n_pulse, 0);
    exp_q.push_back(8'hC4);
    mode = M_FREE;
    drain("R8 subclass0 ready");
    chk(operational_o, "R8 operational subclass0", operational_o, 1);
    subclass1_i = 1;

    finish_run();
  end
endmodule